// File: doc/BRIEF.md
# Hierarchical Row-Column Decoded RAM

This block is a 256-byte random access memory with no clock. It is assembled from level-sensitive one-bit storage cells. Sixteen cells form a 4x4 grid that a row decoder and a column decoder select. Sixteen such grids form a second 4x4 grid, which again has its own row and column decoding. This makes one bit-plane of 256 bits. Eight bit-planes share the address and the store strobe, and each plane holds one bit of the data byte.

At every level a unit is active only when both its row enable and its column enable are high. An inactive unit ignores the store strobe and contributes nothing to the shared read line. Only one unit per level can be active at a time, so the read lines are merged with an AND-OR tree rather than shared tri-state wires.

Reads are purely combinational: the read data follows the address with no clock and no added latency. Writes are transparent for as long as the store strobe is high. The caller must hold the address steady for the whole time the strobe is high. Stored bits come up with arbitrary values and are defined only after they have been written.

Top module: `hram_top`

## Requirements
- R1: Address bits [7:4] pick one of 16 grids, with [5:4] as the grid row and [7:6] as the grid column. Address bits [3:0] pick one cell inside that grid, with [1:0] as the cell row and [3:2] as the cell column. All 256 addresses therefore name distinct storage.
- R2: While `we_i` is high and `addr_i` is held, the addressed byte takes the value of `wdata_i`, and `rdata_o` already shows that value during the strobe.
- R3: `rdata_o` reflects the byte at the current `addr_i` combinationally. No clock edge is needed after the address changes.
- R4: A write to one address leaves the contents of every other address unchanged.
- R5: While `we_i` is low, changes on `wdata_i` have no effect on the stored contents or on `rdata_o`.
- R6: The eight data bits are stored in independent bit-planes. Any bit pattern, including a single set bit or a single cleared bit, is stored and returned exactly.
- R7: A later write to an address replaces the earlier value completely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | 8 | Byte address; see R1 for the field split |
| wdata_i | input | 8 | Data to store |
| we_i | input | 1 | Level-sensitive store strobe, active high |
| rdata_o | output | 8 | Combinational read data for `addr_i` |

## Verification
Two full sweeps over all 256 addresses use two different bijective patterns, one of them complemented. Any aliasing between the row, column or grid fields makes some address read back another address's byte, and that mismatch exposes a wrong split of the address. Walking-one and walking-zero bytes separate a stuck or crossed bit-plane from an addressing fault. Targeted overwrites with neighbour reads, together with data toggling while the strobe is low, separate a store that leaks to other locations or ignores its strobe from a correct write.

// File: rtl/hram_pkg.sv
`timescale 1ns/1ps
package hram_pkg;
  // address bits per decoder; one grid level uses two decoders
  localparam int unsigned SEL_W  = 2;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned LINES  = 1 << SEL_W;
  localparam int unsigned CELLS  = LINES * LINES;
  localparam int unsigned ADDR_W = 4 * SEL_W;
endpackage

// File: rtl/hram_dec.sv
`timescale 1ns/1ps
module hram_dec #(
  parameter int unsigned SEL_W = hram_pkg::SEL_W,
  localparam int unsigned LINES = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic [LINES-1:0] en_o
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign en_o[i] = (sel_i == SEL_W'(i));
  end
endmodule

// File: rtl/hram_cell.sv
`timescale 1ns/1ps
module hram_cell (
  input  logic row_en_i,
  input  logic col_en_i,
  input  logic we_i,
  input  logic d_i,
  output logic q_o
);
  logic sel;
  logic bit_q;

  assign sel = row_en_i & col_en_i;

  // transparent while selected and strobed
  always_latch begin
    if (sel & we_i) bit_q <= d_i;
  end

  // gated drive replaces a tri-state output
  assign q_o = sel & bit_q;
endmodule

// File: rtl/hram_grid.sv
`timescale 1ns/1ps
module hram_grid #(
  parameter int unsigned SEL_W = hram_pkg::SEL_W,
  localparam int unsigned LINES = 1 << SEL_W,
  localparam int unsigned CELLS = LINES * LINES
) (
  input  logic               row_en_i,
  input  logic               col_en_i,
  input  logic               we_i,
  input  logic [2*SEL_W-1:0] addr_i,
  input  logic               d_i,
  output logic               q_o
);
  logic             grid_sel;
  logic             cell_we;
  logic [LINES-1:0] row_en;
  logic [LINES-1:0] col_en;
  logic [CELLS-1:0] cell_q;

  assign grid_sel = row_en_i & col_en_i;
  assign cell_we  = we_i & grid_sel;

  hram_dec #(.SEL_W(SEL_W)) u_row_dec (
    .sel_i (addr_i[SEL_W-1:0]),
    .en_o  (row_en)
  );

  hram_dec #(.SEL_W(SEL_W)) u_col_dec (
    .sel_i (addr_i[2*SEL_W-1:SEL_W]),
    .en_o  (col_en)
  );

  for (genvar r = 0; r < LINES; r++) begin : g_row
    for (genvar c = 0; c < LINES; c++) begin : g_col
      hram_cell u_cell (
        .row_en_i (row_en[r]),
        .col_en_i (col_en[c]),
        .we_i     (cell_we),
        .d_i      (d_i),
        .q_o      (cell_q[r*LINES+c])
      );
    end
  end

  // at most one cell drives high; OR merges, grid select gates
  assign q_o = grid_sel & (|cell_q);
endmodule

// File: rtl/hram_plane.sv
`timescale 1ns/1ps
module hram_plane #(
  parameter int unsigned SEL_W = hram_pkg::SEL_W,
  localparam int unsigned LINES  = 1 << SEL_W,
  localparam int unsigned GRIDS  = LINES * LINES,
  localparam int unsigned ADDR_W = 4 * SEL_W,
  localparam int unsigned IN_W   = 2 * SEL_W
) (
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              d_i,
  output logic              q_o
);
  logic [LINES-1:0] grid_row_en;
  logic [LINES-1:0] grid_col_en;
  logic [GRIDS-1:0] grid_q;

  hram_dec #(.SEL_W(SEL_W)) u_row_dec (
    .sel_i (addr_i[IN_W+SEL_W-1:IN_W]),
    .en_o  (grid_row_en)
  );

  hram_dec #(.SEL_W(SEL_W)) u_col_dec (
    .sel_i (addr_i[ADDR_W-1:IN_W+SEL_W]),
    .en_o  (grid_col_en)
  );

  for (genvar r = 0; r < LINES; r++) begin : g_row
    for (genvar c = 0; c < LINES; c++) begin : g_col
      hram_grid #(.SEL_W(SEL_W)) u_grid (
        .row_en_i (grid_row_en[r]),
        .col_en_i (grid_col_en[c]),
        .we_i     (we_i),
        .addr_i   (addr_i[IN_W-1:0]),
        .d_i      (d_i),
        .q_o      (grid_q[r*LINES+c])
      );
    end
  end

  assign q_o = |grid_q;
endmodule

// File: rtl/hram_top.sv
`timescale 1ns/1ps
module hram_top #(
  parameter int unsigned DATA_W = hram_pkg::DATA_W,
  parameter int unsigned SEL_W  = hram_pkg::SEL_W,
  localparam int unsigned ADDR_W = 4 * SEL_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rdata_o
);
  for (genvar b = 0; b < DATA_W; b++) begin : g_plane
    hram_plane #(.SEL_W(SEL_W)) u_plane (
      .we_i   (we_i),
      .addr_i (addr_i),
      .d_i    (wdata_i[b]),
      .q_o    (rdata_o[b])
    );
  end
endmodule

// File: rtl/hram_chk.sv
`timescale 1ns/1ps
module hram_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              we_i,
  input logic [DATA_W-1:0] rdata_i
);
  logic [DATA_W-1:0] shadow [DEPTH];
  logic [DEPTH-1:0]  known = '0;

  always @(negedge we_i) begin
    shadow[addr_i] <= wdata_i;
    known[addr_i]  <= 1'b1;
  end

  AST_STORE_THROUGH: assert property (@(negedge we_i) rdata_i == wdata_i)
    else $error("store not visible at end of strobe"); // R2

  AST_READ_SHADOW: assert property (@(posedge we_i) known[addr_i] |-> rdata_i == shadow[addr_i])
    else $error("contents differ from last write"); // R4

  always @(addr_i) begin
    AST_ADDR_HELD: assert (!we_i) else $error("address moved during store"); // R2
  end

  always @(wdata_i) begin
    if (!we_i && known[addr_i]) begin
      AST_IDLE_DATA: assert (rdata_i == shadow[addr_i]) else $error("idle data leaked"); // R5
    end
  end
endmodule

bind hram_top hram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .we_i    (we_i),
  .rdata_i (rdata_o)
);

// File: tb/tb_hram_top.sv
`timescale 1ns/1ps
module tb_hram_top;
  logic       clk = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       we = 1'b0;
  logic [7:0] rdata;
  logic [7:0] exp_mem [256];
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hram_top dut (
    .addr_i  (addr),
    .wdata_i (wdata),
    .we_i    (we),
    .rdata_o (rdata)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s addr=%0d actual=%02h expected=%02h", req, addr, act, expv);
    end
  endtask

  task automatic do_write(input int a, input logic [7:0] d);
    @(negedge clk); addr = 8'(a); #1; wdata = d;
    @(negedge clk); we = 1'b1; #2;
    chk("R2", rdata, d);
    @(negedge clk); we = 1'b0;
    exp_mem[a] = d;
  endtask

  // read without any clock edge between address change and sample
  task automatic do_read(input int a, input string req);
    @(negedge clk); addr = 8'(a); #2;
    chk(req, rdata, exp_mem[a]);
  endtask

  function automatic logic [7:0] pat(input int a, input int k);
    if (k == 0) return 8'(a * 7 + 13);
    return ~8'(a * 29 + 3);
  endfunction

  initial begin
    repeat (2) @(negedge clk);

    // R1 R4: full sweep, bijective pattern
    for (int a = 0; a < 256; a++) do_write(a, pat(a, 0));
    for (int a = 0; a < 256; a++) do_read(a, "R1");

    // R3: address change alone updates read data
    do_read(8'h5a, "R3");
    do_read(8'ha5, "R3");

    // R5: data toggling with strobe low
    @(negedge clk); addr = 8'h55; #1;
    for (int i = 0; i < 8; i++) begin
      wdata = ~exp_mem[8'h55] ^ 8'(i);
      #3;
      chk("R5", rdata, exp_mem[8'h55]);
    end
    do_read(8'h37, "R5");
    do_read(8'h55, "R5");

    // R7 R4: overwrite and neighbours
    do_write(255, 8'd150);
    do_write(85, 8'd42);
    do_write(0, 8'd0);
    do_read(255, "R7");
    do_read(85, "R7");
    do_write(85, 8'd200);
    do_read(85, "R7");
    do_read(84, "R4");
    do_read(86, "R4");
    do_read(8'h15, "R4");
    do_read(8'h45, "R4");
    do_read(0, "R4");

    // R6: walking one and walking zero
    for (int i = 0; i < 8; i++) begin
      do_write(i + 16, 8'(1 << i));
      do_write(i + 32, ~8'(1 << i));
    end
    for (int i = 0; i < 8; i++) begin
      do_read(i + 16, "R6");
      do_read(i + 32, "R6");
    end

    // R1 R4: second sweep with a different pattern
    for (int a = 0; a < 256; a++) do_write(a, pat(a, 1));
    for (int a = 255; a >= 0; a--) do_read(a, "R4");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog all requirements actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule